// File: doc/BRIEF.md
# Single-Error-Correcting Sector Parity Code

This block protects a 512-byte storage sector with a 24-bit Hamming-style parity code that corrects one flipped bit. While a sector streams through, one byte per cycle, the generator folds every byte into two 12-bit parity words. The upper word is the XOR of the 12-bit position `{byte_offset, bit_index}` of every data bit that is 1. The lower word is the XOR of the complements of those same positions. Both words are inverted before leaving the block. Because of that inversion, a blank sector (all bytes 0xFF) together with a blank code (all ones) reads as clean.

On the write path, software pulses `code_rd` after the last byte and stores the three bytes of `code_out`, low byte first. On the read path, the sector streams through again and the stored code is presented together with `chk_req`. One cycle later the block reports one of four results: clean, a correctable data error (with byte offset and bit index), an error confined to the stored code, or an uncorrectable error. Any of `start`, `code_rd` or `chk_req` clears the accumulator for the next sector. The data rewrite itself is done outside the block.

Top module: `ecc_sector_hamming`

## Requirements
- R1: After reset, `code_out` is 24'hFFFFFF, `raw_code` is 0 and `chk_valid` is 0.
- R2: After a sector is streamed, `code_out[23:12]` is the inverse of the XOR of the positions `{offset[8:0], bit[2:0]}` of all 1 bits in the sector. `code_out[11:0]` is the inverse of the XOR of the complements of those positions. The first stored byte is `code_out[7:0]`.
- R3: `raw_code` holds the un-inverted lower word in bits 11:0 and the un-inverted upper word in bits 27:16. Bits 15:12 and 31:28 are 0.
- R4: A cycle with `start`, `code_rd` or `chk_req` high clears the parity words and the byte offset. A byte accepted in that same cycle becomes offset 0 of the new sector.
- R5: A sector of 512 bytes of 0xFF yields `code_out` = 24'hFFFFFF.
- R6: `chk_valid` is high exactly in the cycle after `chk_req`. The result classifies the syndrome `stored_code ^ code_out`, taken in the request cycle.
- R7: A zero syndrome gives status 2'b00 (clean).
- R8: If the syndrome's bits 11:0 XOR bits 23:12 equal 12'hFFF, the status is 2'b01 (data error). In that case `err_byte` = syndrome[23:15] and `err_bit` = syndrome[14:12]. If the offset is at or beyond the sector length, the status is 2'b11 instead.
- R9: A syndrome with exactly one bit set gives status 2'b10 (error in the code only).
- R10: Any other nonzero syndrome gives status 2'b11 (uncorrectable). `err_byte` and `err_bit` are 0 whenever the status is not 2'b01.
- R11: With `in_valid` low and no clear source high, `code_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new sector (clears accumulator) |
| in_valid | input | 1 | `in_byte` carries a sector byte this cycle |
| in_byte | input | 8 | Sector data byte |
| code_rd | input | 1 | Code taken by the writer; clears accumulator |
| chk_req | input | 1 | Compare `stored_code` with the running code; clears accumulator |
| stored_code | input | 24 | Code read back from storage, first byte in bits 7:0 |
| code_out | output | 24 | Inverted packed code of the bytes accumulated so far |
| raw_code | output | 32 | Un-inverted parity words in the unpacked layout |
| chk_valid | output | 1 | Check result valid (one cycle) |
| chk_status | output | 2 | 00 clean, 01 data error, 10 code error, 11 uncorrectable |
| err_byte | output | 9 | Byte offset of the data error |
| err_bit | output | 3 | Bit index of the data error |

## Verification
The bench flips single data bits at random positions and also at the extremes (byte 0 bit 0, byte 511 bit 7). A swapped half or a bad bit-index fold would show up here as a wrong offset or a misclassification. It flips single bits in the stored code; a design that tested for complementary halves before testing for a single set bit would still pass this, but a missing single-bit test would report uncorrectable. It also uses double data errors, whose halves are equal rather than complementary and so must not look correctable. The remaining cases are the blank sector, where a missing inversion would break the clean check, and a byte that arrives in the same cycle as a clear, which a wrong priority would drop or count at the old offset.

// File: rtl/ecc_pkg.sv
`timescale 1ns/1ps
package ecc_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN     = 2'b00,
    ST_DATA_FIX  = 2'b01,
    ST_CODE_ONLY = 2'b10,
    ST_UNCORR    = 2'b11
  } ecc_status_e;

  localparam int RAW_W      = 32;
  localparam int RAW_HI_LSB = 16;
endpackage

// File: rtl/ecc_byte_contrib.sv
`timescale 1ns/1ps
// Parity contribution of one byte at a given offset to both words.
module ecc_byte_contrib #(
  parameter int ADDR_W = 9,
  parameter int HW     = ADDR_W + 3
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [7:0]        data,
  output logic [HW-1:0]     hi_term,
  output logic [HW-1:0]     lo_term
);
  logic [2:0] idx_fold;
  logic [2:0] idx_fold_n;
  logic       byte_par;

  always_comb begin
    idx_fold   = 3'd0;
    idx_fold_n = 3'd0;
    for (int i = 0; i < 8; i++) begin
      if (data[i]) begin
        idx_fold   = idx_fold ^ 3'(i);
        idx_fold_n = idx_fold_n ^ ~3'(i);
      end
    end
    byte_par = ^data;
    hi_term  = {(byte_par ? offset : {ADDR_W{1'b0}}), idx_fold};
    lo_term  = {(byte_par ? ~offset : {ADDR_W{1'b0}}), idx_fold_n};
  end
endmodule

// File: rtl/ecc_accum.sv
`timescale 1ns/1ps
// Running parity words and byte offset for the current sector.
module ecc_accum #(
  parameter int ADDR_W = 9,
  parameter int HW     = ADDR_W + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  output logic [HW-1:0] hi_word,
  output logic [HW-1:0] lo_word
);
  logic [ADDR_W-1:0] off_q, off_base, off_d;
  logic [HW-1:0]     hi_q, hi_base, hi_d;
  logic [HW-1:0]     lo_q, lo_base, lo_d;
  logic [HW-1:0]     hi_term, lo_term;
  logic              load_en;

  ecc_byte_contrib #(.ADDR_W(ADDR_W), .HW(HW)) u_contrib (
    .offset (off_base),
    .data   (in_byte),
    .hi_term(hi_term),
    .lo_term(lo_term)
  );

  always_comb begin
    off_base = clear ? '0 : off_q;
    hi_base  = clear ? '0 : hi_q;
    lo_base  = clear ? '0 : lo_q;
    off_d    = off_base;
    hi_d     = hi_base;
    lo_d     = lo_base;
    if (in_valid) begin
      off_d = off_base + 1'b1;
      hi_d  = hi_base ^ hi_term;
      lo_d  = lo_base ^ lo_term;
    end
    load_en = clear | in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else if (load_en) begin
      off_q <= off_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
    end
  end

  assign hi_word = hi_q;
  assign lo_word = lo_q;
endmodule

// File: rtl/ecc_syndrome_class.sv
`timescale 1ns/1ps
// Syndrome formation, classification and registered result.
module ecc_syndrome_class
  import ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_W       = $clog2(SECTOR_BYTES),
  parameter int HW           = ADDR_W + 3,
  parameter int CW           = 2 * HW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [CW-1:0]     stored,
  input  logic [CW-1:0]     computed,
  output logic              valid,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] err_byte,
  output logic [2:0]        err_bit
);
  localparam logic [ADDR_W:0] OFF_LIMIT = (ADDR_W + 1)'(SECTOR_BYTES);

  logic [CW-1:0]     syn;
  logic [HW-1:0]     syn_lo, syn_hi;
  logic              off_over;
  ecc_status_e       st_d;
  logic [ADDR_W-1:0] byte_d;
  logic [2:0]        bit_d;

  logic              valid_q;
  ecc_status_e       st_q;
  logic [ADDR_W-1:0] byte_q;
  logic [2:0]        bit_q;

  always_comb begin
    syn      = stored ^ computed;
    syn_lo   = syn[HW-1:0];
    syn_hi   = syn[CW-1:HW];
    off_over = {1'b0, syn_hi[HW-1:3]} >= OFF_LIMIT;
    st_d     = ST_CLEAN;
    byte_d   = '0;
    bit_d    = '0;
    if (syn != '0) begin
      if ((syn_lo ^ syn_hi) == {HW{1'b1}}) begin
        if (off_over) begin
          st_d = ST_UNCORR;
        end else begin
          st_d   = ST_DATA_FIX;
          byte_d = syn_hi[HW-1:3];
          bit_d  = syn_hi[2:0];
        end
      end else if ((syn & (syn - 1'b1)) == '0) begin
        st_d = ST_CODE_ONLY;
      end else begin
        st_d = ST_UNCORR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      st_q    <= ST_CLEAN;
      byte_q  <= '0;
      bit_q   <= '0;
    end else begin
      valid_q <= req;
      if (req) begin
        st_q   <= st_d;
        byte_q <= byte_d;
        bit_q  <= bit_d;
      end
    end
  end

  assign valid    = valid_q;
  assign status   = st_q;
  assign err_byte = byte_q;
  assign err_bit  = bit_q;
endmodule

// File: rtl/ecc_sector_hamming.sv
`timescale 1ns/1ps
module ecc_sector_hamming
  import ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_W       = $clog2(SECTOR_BYTES),
  parameter int HW           = ADDR_W + 3,
  parameter int CW           = 2 * HW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              code_rd,
  input  logic              chk_req,
  input  logic [CW-1:0]     stored_code,
  output logic [CW-1:0]     code_out,
  output logic [RAW_W-1:0]  raw_code,
  output logic              chk_valid,
  output logic [1:0]        chk_status,
  output logic [ADDR_W-1:0] err_byte,
  output logic [2:0]        err_bit
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          acc_clear;
  logic [HW-1:0] hi_word, lo_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign acc_clear = start | code_rd | chk_req;

  ecc_accum #(.ADDR_W(ADDR_W), .HW(HW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clear   (acc_clear),
    .in_valid(in_valid),
    .in_byte (in_byte),
    .hi_word (hi_word),
    .lo_word (lo_word)
  );

  assign code_out = ~{hi_word, lo_word};

  always_comb begin
    raw_code = '0;
    raw_code[HW-1:0]                    = lo_word;
    raw_code[RAW_HI_LSB +: HW]          = hi_word;
  end

  ecc_syndrome_class #(
    .SECTOR_BYTES(SECTOR_BYTES), .ADDR_W(ADDR_W), .HW(HW), .CW(CW)
  ) u_cls (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .req     (chk_req),
    .stored  (stored_code),
    .computed(code_out),
    .valid   (chk_valid),
    .status  (chk_status),
    .err_byte(err_byte),
    .err_bit (err_bit)
  );
endmodule

// File: rtl/ecc_sector_hamming_chk.sv
`timescale 1ns/1ps
module ecc_sector_hamming_chk #(
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_W       = $clog2(SECTOR_BYTES),
  parameter int CW           = 2 * (ADDR_W + 3)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              in_valid,
  input logic              code_rd,
  input logic              chk_req,
  input logic [CW-1:0]     stored_code,
  input logic [CW-1:0]     code_out,
  input logic              chk_valid,
  input logic [1:0]        chk_status,
  input logic [ADDR_W-1:0] err_byte,
  input logic [2:0]        err_bit
);
  a_r6_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |=> chk_valid);
  a_r6_no_valid_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_req |=> !chk_valid);
  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (start || code_rd || chk_req) && !in_valid |=> code_out == {CW{1'b1}});
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !start && !code_rd && !chk_req |=> $stable(code_out));
  a_r7_clean_means_equal: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_status == 2'b00 |-> $past(stored_code) == $past(code_out));
  a_r9_code_only_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_status == 2'b10 |-> $countones($past(stored_code ^ code_out)) == 1);
  a_r10_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_status != 2'b01 |-> err_byte == '0 && err_bit == '0);
endmodule

bind ecc_sector_hamming ecc_sector_hamming_chk #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
  .code_rd(code_rd), .chk_req(chk_req), .stored_code(stored_code),
  .code_out(code_out), .chk_valid(chk_valid), .chk_status(chk_status),
  .err_byte(err_byte), .err_bit(err_bit)
);

// File: tb/sim_ecc_sector_hamming.sv
`timescale 1ns/1ps
module sim_ecc_sector_hamming;
  localparam int NB = 512;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, in_valid, code_rd, chk_req;
  logic [7:0]  in_byte;
  logic [23:0] stored_code;
  logic [23:0] code_out;
  logic [31:0] raw_code;
  logic        chk_valid;
  logic [1:0]  chk_status;
  logic [8:0]  err_byte;
  logic [2:0]  err_bit;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] sec [NB];

  always #2.5 clk = ~clk;

  ecc_sector_hamming u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_byte(in_byte), .code_rd(code_rd), .chk_req(chk_req),
    .stored_code(stored_code), .code_out(code_out), .raw_code(raw_code),
    .chk_valid(chk_valid), .chk_status(chk_status),
    .err_byte(err_byte), .err_bit(err_bit)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // stored-form code of the array, computed bit by bit
  function automatic logic [23:0] model_code();
    logic [11:0] hi, lo, pos;
    hi = '0; lo = '0;
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 8; i++)
        if (sec[b][i]) begin
          pos = {9'(b), 3'(i)};
          hi  = hi ^ pos;
          lo  = lo ^ ~pos;
        end
    return ~{hi, lo};
  endfunction

  task automatic fill_random();
    for (int b = 0; b < NB; b++) sec[b] = 8'($urandom);
  endtask

  task automatic flip(input int p);
    sec[p >> 3][p & 7] = ~sec[p >> 3][p & 7];
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic stream(input int first);
    for (int b = first; b < NB; b++) begin
      @(negedge clk); in_valid = 1'b1; in_byte = sec[b];
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic do_check(input logic [23:0] st, input logic [1:0] es,
                          input logic [8:0] eb, input logic [2:0] ei, input string req);
    @(negedge clk); chk_req = 1'b1; stored_code = st;
    @(negedge clk); chk_req = 1'b0;
    check(chk_valid === 1'b1, "R6 valid", 32'(chk_valid), 32'd1);
    check(chk_status === es, req, 32'(chk_status), 32'(es));
    check(err_byte === eb && err_bit === ei, req,
          {20'd0, err_byte, err_bit}, {20'd0, eb, ei});
    @(negedge clk);
    check(chk_valid === 1'b0, "R6 one cycle", 32'(chk_valid), 32'd0);
    check(code_out === 24'hFFFFFF, "R4 chk clears", 32'(code_out), 32'hFFFFFF);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] good;
    logic [23:0] hold;
    int p1, p2;
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 0; in_valid = 0; code_rd = 0; chk_req = 0;
    in_byte = 0; stored_code = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(code_out === 24'hFFFFFF, "R1 code", 32'(code_out), 32'hFFFFFF);
    check(raw_code === 32'd0, "R1 raw", raw_code, 32'd0);
    check(chk_valid === 1'b0, "R1 valid", 32'(chk_valid), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 / R3 random sectors, then R4 clear by code_rd
    for (int s = 0; s < 5; s++) begin
      fill_random();
      good = model_code();
      pulse_start();
      stream(0);
      check(code_out === good, "R2 code", 32'(code_out), 32'(good));
      check(raw_code === {4'h0, ~good[23:12], 4'h0, ~good[11:0]}, "R3 raw",
            raw_code, {4'h0, ~good[23:12], 4'h0, ~good[11:0]});
      hold = code_out;
      repeat (4) @(negedge clk);
      check(code_out === hold, "R11 idle", 32'(code_out), 32'(hold));
      @(negedge clk); code_rd = 1'b1;
      @(negedge clk); code_rd = 1'b0;
      check(code_out === 24'hFFFFFF, "R4 rd clears", 32'(code_out), 32'hFFFFFF);
    end

    // R7 clean
    fill_random(); good = model_code();
    stream(0);
    do_check(good, 2'b00, 9'd0, 3'd0, "R7 clean");

    // R8 single data errors, including extremes
    for (int s = 0; s < 8; s++) begin
      fill_random(); good = model_code();
      p1 = (s == 0) ? 0 : (s == 1) ? NB * 8 - 1 : int'($urandom_range(NB * 8 - 1));
      flip(p1);
      stream(0);
      do_check(good, 2'b01, 9'(p1 >> 3), 3'(p1 & 7), "R8 data error");
    end

    // R9 single code bit errors
    for (int s = 0; s < 4; s++) begin
      fill_random(); good = model_code();
      stream(0);
      p1 = (s == 0) ? 23 : int'($urandom_range(23));
      do_check(good ^ (24'd1 << p1), 2'b10, 9'd0, 3'd0, "R9 code error");
    end

    // R10 double data errors
    for (int s = 0; s < 4; s++) begin
      fill_random(); good = model_code();
      p1 = int'($urandom_range(NB * 8 - 1));
      p2 = (p1 + 1 + int'($urandom_range(NB * 8 - 2))) % (NB * 8);
      flip(p1); flip(p2);
      stream(0);
      do_check(good, 2'b11, 9'd0, 3'd0, "R10 uncorrectable");
    end

    // R5 erased sector
    for (int b = 0; b < NB; b++) sec[b] = 8'hFF;
    stream(0);
    check(code_out === 24'hFFFFFF, "R5 erased", 32'(code_out), 32'hFFFFFF);
    do_check(24'hFFFFFF, 2'b00, 9'd0, 3'd0, "R5 erased checks clean");

    // R4 start mid-sector, then same-cycle clear with a byte
    fill_random(); good = model_code();
    for (int b = 0; b < 100; b++) begin
      @(negedge clk); in_valid = 1'b1; in_byte = 8'($urandom);
    end
    @(negedge clk); in_valid = 1'b0;
    pulse_start();
    stream(0);
    check(code_out === good, "R4 start mid-sector", 32'(code_out), 32'(good));
    fill_random(); good = model_code();
    @(negedge clk); code_rd = 1'b1; in_valid = 1'b1; in_byte = sec[0];
    @(negedge clk); code_rd = 1'b0; in_valid = 1'b0;
    stream(1);
    check(code_out === good, "R4 byte with clear", 32'(code_out), 32'(good));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule